// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block runs the digital half of a successive-approximation analog-to-digital conversion. It drives a trial code to an external DAC and reads back one comparator bit per trial. It resolves the code one bit at a time, from the most significant bit down. A conversion is either a full 12-bit cycle or a short 8-bit cycle. The DAC, the comparator, the voltage reference and the clock source all sit outside the block.

Three control levels qualify a start: chip enable high, chip select low, and read/convert at its convert level (low). A conversion begins on the clock where all three first hold together, so whichever input settles last triggers it. On that start the block samples the length select. While a conversion runs, the busy output stays high and further start transitions cannot restart or abort it. Such a transition still samples the length select again. The finished code is copied into the result register in one step, on the edge where busy falls.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts on the first clock at which chip_en=1, chip_sel_n=0 and conv_read=0 all hold together, whichever of them arrives last. busy reads 1 from the following clock edge.
- R2: len_sel is sampled at the start. A value of 1 gives an 8-bit cycle and 0 gives a 12-bit cycle. busy stays high for exactly TRIAL_CYCLES×8 clocks (short) or TRIAL_CYCLES×12 clocks (full), where TRIAL_CYCLES defaults to 2.
- R3: busy is 0 whenever no conversion runs. With any one of the three qualifying inputs not at its required level, no conversion starts.
- R4: A start transition while busy is high neither restarts nor aborts the running conversion.
- R5: A start transition while busy is high samples len_sel again, and the new value sets the length of the running conversion.
- R6: Bits are resolved from bit 11 down to bit 0. Each trial sets the bit under test and keeps it only when cmp_above=1 (input at or above the DAC code). With an ideal comparator, a full conversion yields the input code itself.
- R7: After an 8-bit cycle, result[11:4] holds the resolved bits, result[3] is 1 and result[2:0] are 0.
- R8: result keeps its previous value for the whole of a conversion and changes only on the edge where busy falls.
- R9: A synchronous active-high rst clears busy, result and dac_code.
- R10: During the trial for bit k, dac_code has bit k set and every bit below k cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| conv_read | input | 1 | 1 = read, 0 = convert |
| len_sel | input | 1 | Length select: 1 = 8-bit cycle, 0 = 12-bit cycle |
| cmp_above | input | 1 | Comparator: 1 when the analog input is at or above the DAC output |
| busy | output | 1 | High while a conversion is in progress |
| dac_code | output | 12 | Trial code to the DAC |
| result | output | 12 | Last completed conversion |

## Verification
The assertions assume that cmp_above is settled and stable when the last cycle of each bit trial samples it. They also assume that the control inputs change only away from the clock edge, so that each start is seen as a clean level change on one edge. The bench models the comparator as a combinational compare of a held digital input value against dac_code. It changes that value only between conversions. All control levels are driven on the falling clock edge.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Conversion length, sampled at a start event
    typedef enum logic {
        LEN_FULL  = 1'b0,
        LEN_SHORT = 1'b1
    } len_e;

    // Start event handed from the start detector to the bit engine
    typedef struct packed {
        logic fire;   // one-cycle start transition
        len_e len;    // most recently latched length
    } start_t;

    // Index of the final bit trial for a given length
    function automatic int last_trial(len_e len, int width, int short_bits);
        return (len == LEN_SHORT) ? (width - short_bits) : 0;
    endfunction

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect
    import sar_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   chip_en,
    input  logic   chip_sel_n,
    input  logic   conv_read,
    input  logic   len_sel,
    output start_t evt
);
    logic cond;
    logic cond_q;
    len_e len_q;

    // All three qualifiers at their convert levels
    assign cond = chip_en & ~chip_sel_n & ~conv_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b1;      // a fresh transition is needed after reset
            len_q  <= LEN_FULL;
        end else begin
            cond_q <= cond;
            if (cond && !cond_q)
                len_q <= len_e'(len_sel);
        end
    end

    assign evt.fire = cond & ~cond_q;
    assign evt.len  = len_q;

    // R5
    len_relatch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(evt.fire) |-> (evt.len == len_e'($past(len_sel))));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
    import sar_pkg::*;
#(
    parameter int WIDTH        = 12,
    parameter int SHORT_BITS   = 8,
    parameter int TRIAL_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  start_t           evt,
    input  logic             cmp_above,
    output logic             busy,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result
);
    localparam int IDX_W      = $clog2(WIDTH);
    localparam int PH_W       = $clog2(TRIAL_CYCLES + 1);
    localparam int SHORT_LAST = WIDTH - SHORT_BITS;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(TRIAL_CYCLES - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [PH_W-1:0]  ph_q;
    logic [WIDTH-1:0] sar_q;
    logic [WIDTH-1:0] result_q;

    logic [IDX_W-1:0] last_idx;
    logic             decide;
    logic [WIDTH-1:0] bit_mask;
    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] final_code;

    always_comb begin
        last_idx = IDX_W'(last_trial(evt.len, WIDTH, SHORT_BITS));
        decide   = busy_q && (ph_q == PH_LAST);
        bit_mask = WIDTH'(1) << idx_q;
        kept     = cmp_above ? sar_q : (sar_q & ~bit_mask);
        final_code = kept;
        if (evt.len == LEN_SHORT) begin
            for (int i = 0; i < SHORT_LAST; i++)
                final_code[i] = (i == SHORT_LAST - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            idx_q    <= '0;
            ph_q     <= '0;
            sar_q    <= '0;
            result_q <= '0;
        end else if (!busy_q) begin
            if (evt.fire) begin
                busy_q <= 1'b1;
                idx_q  <= TOP_IDX;
                ph_q   <= '0;
                sar_q  <= WIDTH'(1) << TOP_IDX;
            end
        end else if (!decide) begin
            ph_q <= ph_q + 1'b1;
        end else if (idx_q <= last_idx) begin
            busy_q   <= 1'b0;
            sar_q    <= kept;
            result_q <= final_code;
        end else begin
            sar_q <= kept | (bit_mask >> 1);
            idx_q <= idx_q - 1'b1;
            ph_q  <= '0;
        end
    end

    assign busy     = busy_q;
    assign dac_code = sar_q;
    assign result   = result_q;

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(evt.fire));

    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> (idx_q <= $past(idx_q)));

    // R8
    result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(result_q));

    // R7
    short_tail_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_q) && evt.len == LEN_SHORT) |-> (result_q[SHORT_LAST-1:0] == WIDTH'(1) << (SHORT_LAST-1)));

    // R10
    trial_code_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (sar_q[idx_q] && ((sar_q & ((WIDTH'(1) << idx_q) - 1'b1)) == '0)));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH        = 12,
    parameter int SHORT_BITS   = 8,
    parameter int TRIAL_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chip_en,
    input  logic             chip_sel_n,
    input  logic             conv_read,
    input  logic             len_sel,
    input  logic             cmp_above,
    output logic             busy,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result
);
    start_t evt;

    sar_start_detect u_start (
        .clk        (clk),
        .rst        (rst),
        .chip_en    (chip_en),
        .chip_sel_n (chip_sel_n),
        .conv_read  (conv_read),
        .len_sel    (len_sel),
        .evt        (evt)
    );

    sar_bit_engine #(
        .WIDTH        (WIDTH),
        .SHORT_BITS   (SHORT_BITS),
        .TRIAL_CYCLES (TRIAL_CYCLES)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cmp_above (cmp_above),
        .busy      (busy),
        .dac_code  (dac_code),
        .result    (result)
    );

    // R3
    idle_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> !busy);

endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb_top;
    localparam int T = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en = 1'b0;
    logic        chip_sel_n = 1'b1;
    logic        conv_read = 1'b1;
    logic        len_sel = 1'b0;
    logic [11:0] vin = '0;
    logic        cmp_above;
    logic        busy;
    logic [11:0] dac_code;
    logic [11:0] result;

    int runs = 0;
    int fails = 0;
    int wd = 0;
    logic [11:0] prev_res = '0;

    always #4 clk = ~clk;   // 125 MHz

    assign cmp_above = (vin >= dac_code);

    sar_conv_ctrl dut_i (
        .clk(clk), .rst(rst), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
        .conv_read(conv_read), .len_sel(len_sel), .cmp_above(cmp_above),
        .busy(busy), .dac_code(dac_code), .result(result)
    );

    // {last(2), short(1), pad(1), vin(12)}; last: 0 chip_en, 1 chip_sel_n, 2 conv_read
    localparam logic [15:0] VEC [8] = '{
        {2'd0, 1'b0, 1'b0, 12'hABC},
        {2'd1, 1'b0, 1'b0, 12'h000},
        {2'd2, 1'b0, 1'b0, 12'hFFF},
        {2'd0, 1'b1, 1'b0, 12'h5A7},
        {2'd1, 1'b1, 1'b0, 12'hFFF},
        {2'd2, 1'b1, 1'b0, 12'h009},
        {2'd2, 1'b0, 1'b0, 12'h800},
        {2'd1, 1'b0, 1'b0, 12'h7FF}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] expect_code(input logic [11:0] v, input bit s);
        return s ? {v[11:4], 4'b1000} : v;
    endfunction

    task automatic go_idle();
        chip_en = 1'b0; chip_sel_n = 1'b1; conv_read = 1'b1;
    endtask

    // Arm two qualifiers, then apply the last one
    task automatic start_conv(input int last);
        @(negedge clk);
        chip_en    = (last != 0);
        chip_sel_n = (last == 1);
        conv_read  = (last == 2);
        @(negedge clk);
        chip_en = 1'b1; chip_sel_n = 1'b0; conv_read = 1'b0;
        @(negedge clk);
    endtask

    task automatic count_busy(output int cnt);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("[TB] %0d tests run, %0d failed", runs + 1, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy == 1'b0, "R9 busy", busy, 0);
        chk(result == 12'h0, "R9 result", result, 0);
        chk(dac_code == 12'h0, "R9 dac_code", dac_code, 0);
        rst = 1'b0;
        @(negedge clk);

        foreach (VEC[i]) begin
            logic [11:0] v;
            bit s;
            int last;
            v = VEC[i][11:0]; s = VEC[i][13]; last = int'(VEC[i][15:14]);
            vin = v; len_sel = s;
            start_conv(last);
            chk(busy == 1'b1, "R1 busy after start", busy, 1);
            chk(dac_code == 12'h800, "R10 first trial", dac_code, 12'h800);
            chk(result == prev_res, "R8 result held", result, prev_res);
            count_busy(cnt);
            chk(cnt == (s ? 8 * T : 12 * T), "R2 busy length", cnt, s ? 8 * T : 12 * T);
            if (s) chk(result == expect_code(v, 1'b1), "R7 short result", result, expect_code(v, 1'b1));
            else   chk(result == expect_code(v, 1'b0), "R6 full result", result, expect_code(v, 1'b0));
            prev_res = result;
            go_idle();
            @(negedge clk);
            chk(busy == 1'b0, "R3 idle", busy, 0);
        end

        // R3: one qualifier missing, no start
        vin = 12'h333; len_sel = 1'b0;
        chip_en = 1'b1; chip_sel_n = 1'b1; conv_read = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R3 chip_sel_n high", busy, 0);
        chip_en = 1'b0; chip_sel_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R3 chip_en low", busy, 0);
        go_idle();
        @(negedge clk);

        // R4: extra start during busy, same length -> no restart
        vin = 12'h4D2; len_sel = 1'b0;
        start_conv(2);
        repeat (5) @(negedge clk);
        conv_read = 1'b1; @(negedge clk); conv_read = 1'b0;
        count_busy(cnt);
        chk(cnt == 12 * T - 6, "R4 no restart length", cnt, 12 * T - 6);
        chk(result == 12'h4D2, "R4 result", result, 12'h4D2);
        go_idle();
        @(negedge clk);

        // R5: extra start during busy with len_sel=1 shortens the cycle
        vin = 12'hC3E; len_sel = 1'b0;
        start_conv(2);
        repeat (5) @(negedge clk);
        len_sel = 1'b1;
        conv_read = 1'b1; @(negedge clk); conv_read = 1'b0;
        count_busy(cnt);
        chk(cnt == 8 * T - 6, "R5 relatched length", cnt, 8 * T - 6);
        chk(result == 12'hC38, "R5 short result", result, 12'hC38);
        go_idle();
        @(negedge clk);

        // R9: reset mid-conversion
        vin = 12'h111; len_sel = 1'b0;
        start_conv(0);
        repeat (3) @(negedge clk);
        rst = 1'b1; @(negedge clk);
        chk(busy == 1'b0, "R9 mid reset busy", busy, 0);
        chk(result == 12'h0, "R9 mid reset result", result, 0);
        rst = 1'b0;
        go_idle();
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule